// File: doc/BRIEF.md
# Rank-Programmable Shared Memory Arbiter

This block decides which of four requesters owns a shared memory bus. The requesters are a receive DMA engine, a microprocessor, a transmit DMA engine and an interrupt controller. The ranking is not fixed in logic. An 8-bit field is split into four rank slots, and each slot holds a 2-bit code that names the requester placed at that rank. Software can therefore reorder the requesters by writing new codes into the slots.

The arbiter makes a decision only when the bus is free. The bus is free when no grant is outstanding and the external busy input is low. At that point the arbiter scans the slots from the highest rank to the lowest, and the first slot whose named requester is asking wins. The winner keeps its grant until the memory side reports the end of the cycle. The grant is given in two forms: a one-hot vector and the encoded identity of the winner.

Top module: `mem_arb`

## Requirements
- R1: While reset is asserted, and after it is released with no request made, `gnt_o` is all zero and `gnt_id_o` is 0.
- R2: Rank slot k (k = 0 for the highest rank up to 3 for the lowest) is `prio_cfg_i[2k+1:2k]`. Entity codes are 0 for receive DMA, 1 for microprocessor, 2 for transmit DMA and 3 for interrupt controller. The granted entity drives `gnt_o[code]` and `gnt_id_o = code`.
- R3: A decision grants the entity named in the first slot, counting from rank 0, whose entity has its `req_i[code]` bit high.
- R4: With `prio_cfg_i = 8'hE4`, the ranking is receive DMA, then microprocessor, then transmit DMA, then interrupt controller.
- R5: At most one bit of `gnt_o` is high. When no grant is held, `gnt_id_o` is 0.
- R6: A decision is made only when no grant is held and `ext_busy_i` is low. The grant appears in the cycle after the clock edge at which the decision is sampled.
- R7: A held grant stays unchanged, even if its request drops, until an edge at which `cycle_done_i` is high. The grant is zero after that edge, and at least one cycle with no grant passes before the next grant.
- R8: If several slots name the same entity, that entity takes the best of those ranks. An entity named by no slot is never granted, even while it requests.
- R9: Changing `prio_cfg_i` while a grant is held does not alter that grant. The next decision uses the new value.
- R10: `cycle_done_i` has no effect while no grant is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 4 | Request per entity, indexed by entity code |
| prio_cfg_i | input | 8 | Four 2-bit rank slots; bits 1:0 hold the highest rank |
| ext_busy_i | input | 1 | Bus held elsewhere; blocks new decisions |
| cycle_done_i | input | 1 | Current memory cycle finishes at this edge |
| gnt_o | output | 4 | One-hot grant, indexed by entity code |
| gnt_id_o | output | 2 | Code of the granted entity, 0 when idle |

## Verification
Two functions can fall in the same cycle: a rewrite of the rank field, and either the completion of a held cycle or an idle decision. The bench changes `prio_cfg_i` in the middle of a held grant and again on the edge where `cycle_done_i` ends it. The expected result is that the grant does not move, and that the first decision made after the idle cycle follows the new ranking. A behavioural model applies the same rules cycle by cycle, and its output is compared on every clock. The model is driven through directed cases and then a long random mix of requests, busy periods, completions and rank rewrites.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;
  localparam int unsigned ENT_W  = 2;
  localparam int unsigned N_ENT  = 1 << ENT_W;
  localparam int unsigned N_SLOT = 4;
  localparam int unsigned CFG_W  = N_SLOT * ENT_W;

  typedef enum logic [ENT_W-1:0] {
    ENT_RX_DMA = 2'd0,
    ENT_CPU    = 2'd1,
    ENT_TX_DMA = 2'd2,
    ENT_IRQ    = 2'd3
  } ent_e;

  localparam logic [CFG_W-1:0] CFG_DEFAULT = 8'hE4;
endpackage

// File: rtl/arb_slot_scan.sv
module arb_slot_scan #(
  parameter int unsigned ENT_W  = mem_arb_pkg::ENT_W,
  parameter int unsigned N_SLOT = mem_arb_pkg::N_SLOT,
  localparam int unsigned N_ENT = 1 << ENT_W,
  localparam int unsigned CFG_W = N_SLOT * ENT_W
) (
  input  logic [N_ENT-1:0] req_i,
  input  logic [CFG_W-1:0] prio_cfg_i,
  output logic             win_vld_o,
  output logic [ENT_W-1:0] win_id_o
);
  logic [ENT_W-1:0] slot_code [N_SLOT];
  logic [N_SLOT-1:0] slot_hit;

  for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
    assign slot_code[s] = prio_cfg_i[s*ENT_W +: ENT_W];
    assign slot_hit[s]  = req_i[slot_code[s]];
  end

  // lowest slot index = highest rank; scan downward so rank 0 overrides
  always_comb begin
    win_vld_o = 1'b0;
    win_id_o  = '0;
    for (int s = N_SLOT - 1; s >= 0; s--) begin
      if (slot_hit[s]) begin
        win_vld_o = 1'b1;
        win_id_o  = slot_code[s];
      end
    end
  end
endmodule

// File: rtl/arb_grant_hold.sv
module arb_grant_hold #(
  parameter int unsigned ENT_W = mem_arb_pkg::ENT_W,
  localparam int unsigned N_ENT = 1 << ENT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_vld_i,
  input  logic [ENT_W-1:0] win_id_i,
  input  logic             ext_busy_i,
  input  logic             cycle_done_i,
  output logic [N_ENT-1:0] gnt_o,
  output logic [ENT_W-1:0] gnt_id_o
);
  logic             own_q;
  logic [ENT_W-1:0] id_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q <= 1'b0;
      id_q  <= '0;
    end else if (!own_q) begin
      if (win_vld_i && !ext_busy_i) begin
        own_q <= 1'b1;
        id_q  <= win_id_i;
      end
    end else if (cycle_done_i) begin
      own_q <= 1'b0;
    end
  end

  for (genvar e = 0; e < N_ENT; e++) begin : g_dec
    assign gnt_o[e] = own_q && (id_q == ENT_W'(e));
  end
  assign gnt_id_o = own_q ? id_q : '0;

  a_r5_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  a_r5_idle_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0) |-> (gnt_id_o == '0));
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o != '0) && !cycle_done_i) |=> $stable(gnt_o));
  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o != '0) && cycle_done_i) |=> (gnt_o == '0));
  a_r6_busy_block: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o == '0) && ext_busy_i) |=> (gnt_o == '0));
endmodule

// File: rtl/mem_arb.sv
module mem_arb #(
  parameter int unsigned ENT_W  = mem_arb_pkg::ENT_W,
  parameter int unsigned N_SLOT = mem_arb_pkg::N_SLOT,
  localparam int unsigned N_ENT = 1 << ENT_W,
  localparam int unsigned CFG_W = N_SLOT * ENT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_ENT-1:0] req_i,
  input  logic [CFG_W-1:0] prio_cfg_i,
  input  logic             ext_busy_i,
  input  logic             cycle_done_i,
  output logic [N_ENT-1:0] gnt_o,
  output logic [ENT_W-1:0] gnt_id_o
);
  logic             win_vld;
  logic [ENT_W-1:0] win_id;

  arb_slot_scan #(.ENT_W(ENT_W), .N_SLOT(N_SLOT)) u_scan (
    .req_i      (req_i),
    .prio_cfg_i (prio_cfg_i),
    .win_vld_o  (win_vld),
    .win_id_o   (win_id)
  );

  arb_grant_hold #(.ENT_W(ENT_W)) u_hold (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .win_vld_i    (win_vld),
    .win_id_i     (win_id),
    .ext_busy_i   (ext_busy_i),
    .cycle_done_i (cycle_done_i),
    .gnt_o        (gnt_o),
    .gnt_id_o     (gnt_id_o)
  );

  // previous-cycle request and naming, kept for the checks below
  logic [N_ENT-1:0] named_w, named_d, req_d;
  always_comb begin
    named_w = '0;
    for (int s = 0; s < N_SLOT; s++) named_w[prio_cfg_i[s*ENT_W +: ENT_W]] = 1'b1;
  end
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      named_d <= '0;
      req_d   <= '0;
    end else begin
      named_d <= named_w;
      req_d   <= req_i;
    end
  end

  a_r3_grant_was_requested: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|gnt_o) |-> req_d[gnt_id_o]);
  a_r8_grant_was_named: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|gnt_o) |-> named_d[gnt_id_o]);
endmodule

// File: tb/mem_arb_tb.sv
module mem_arb_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] req_i = '0;
  logic [7:0] prio_cfg_i = 8'hE4;
  logic       ext_busy_i = 1'b0;
  logic       cycle_done_i = 1'b0;
  logic [3:0] gnt_o;
  logic [1:0] gnt_id_o;

  int n_chk = 0;
  int n_fail = 0;
  int model_gnt = -1;
  string cur_req = "R1";
  bit done_run = 1'b0;

  always #5 clk_i = ~clk_i;

  mem_arb u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .prio_cfg_i(prio_cfg_i),
    .ext_busy_i(ext_busy_i), .cycle_done_i(cycle_done_i),
    .gnt_o(gnt_o), .gnt_id_o(gnt_id_o)
  );

  task automatic compare();
    logic [3:0] eg;
    logic [1:0] ei;
    eg = (model_gnt < 0) ? 4'b0 : 4'(1 << model_gnt);
    ei = (model_gnt < 0) ? 2'd0 : 2'(model_gnt);
    n_chk++;
    if (gnt_o !== eg || gnt_id_o !== ei) begin
      n_fail++;
      $display("FAIL %s: gnt=%b id=%0d expected gnt=%b id=%0d", cur_req, gnt_o, gnt_id_o, eg, ei);
    end
  endtask

  task automatic model_edge();
    if (model_gnt < 0) begin
      if (!ext_busy_i) begin
        for (int s = 0; s < 4; s++) begin
          int e;
          e = int'(prio_cfg_i[2*s +: 2]);
          if (req_i[e]) begin
            model_gnt = e;
            break;
          end
        end
      end
    end else if (cycle_done_i) begin
      model_gnt = -1;
    end
  endtask

  task automatic step(input logic [3:0] rq, input logic [7:0] cfg, input logic busy, input logic done);
    req_i = rq; prio_cfg_i = cfg; ext_busy_i = busy; cycle_done_i = done;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    compare();
  endtask

  initial begin
    cur_req = "R1";
    repeat (3) @(negedge clk_i);
    compare();
    rst_ni = 1'b1;
    step(4'b0000, 8'hE4, 0, 0);
    step(4'b0000, 8'hE4, 0, 0);

    cur_req = "R4";
    step(4'b1111, 8'hE4, 0, 0);
    step(4'b1111, 8'hE4, 0, 1);
    step(4'b1110, 8'hE4, 0, 0);
    step(4'b1110, 8'hE4, 0, 1);
    step(4'b1100, 8'hE4, 0, 0);
    step(4'b1100, 8'hE4, 0, 1);

    cur_req = "R2";
    step(4'b1111, 8'h1B, 0, 0);
    step(4'b1111, 8'h1B, 0, 1);
    step(4'b0110, 8'h1B, 0, 0);
    step(4'b0110, 8'h1B, 0, 1);

    cur_req = "R3";
    step(4'b1001, 8'h4E, 0, 0);
    step(4'b1001, 8'h4E, 0, 1);
    step(4'b0001, 8'h4E, 0, 0);
    step(4'b0001, 8'h4E, 0, 1);

    cur_req = "R6";
    step(4'b0100, 8'hE4, 1, 0);
    step(4'b0100, 8'hE4, 1, 0);
    step(4'b0100, 8'hE4, 0, 0);
    step(4'b0100, 8'hE4, 1, 0);
    step(4'b0100, 8'hE4, 1, 1);

    cur_req = "R7";
    step(4'b0010, 8'hE4, 0, 0);
    step(4'b0000, 8'hE4, 0, 0);
    step(4'b1111, 8'hE4, 0, 0);
    step(4'b1111, 8'hE4, 0, 1);
    step(4'b1111, 8'hE4, 0, 0);
    step(4'b1111, 8'hE4, 0, 1);

    cur_req = "R8";
    step(4'b0010, 8'h00, 0, 0);
    step(4'b1110, 8'h00, 0, 0);
    step(4'b1110, 8'h00, 0, 0);
    step(4'b1100, 8'hDD, 0, 0);
    step(4'b1100, 8'hDD, 0, 1);
    step(4'b0101, 8'hDD, 0, 0);
    step(4'b0101, 8'hDD, 0, 1);

    cur_req = "R9";
    step(4'b1111, 8'hE4, 0, 0);
    step(4'b1111, 8'h1B, 0, 0);
    step(4'b1111, 8'h4E, 0, 1);
    step(4'b1111, 8'h1B, 0, 0);
    step(4'b1111, 8'hE4, 0, 1);

    cur_req = "R10";
    step(4'b0000, 8'hE4, 0, 1);
    step(4'b0000, 8'hE4, 0, 1);
    step(4'b1000, 8'hE4, 0, 1);
    step(4'b1000, 8'hE4, 0, 0);
    step(4'b0000, 8'hE4, 0, 1);

    cur_req = "R5";
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] c;
      c = ($urandom % 8 == 0) ? 8'($urandom) : prio_cfg_i;
      step(4'($urandom), c, ($urandom % 4) == 0, ($urandom % 3) == 0);
    end

    done_run = 1'b1;
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done_run && cyc < 100000) begin
      @(posedge clk_i);
      cyc++;
    end
    if (!done_run) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected fewer", cyc);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule